// File: doc/BRIEF.md
# Dual-Mode SPI Register Access Engine

This block is an SPI master that performs exactly one register transaction at a time against a radio transceiver. Each request carries a direction (read or write), an address-space selector (short, 6-bit addresses; or long, 10-bit addresses), an address and, for writes, one data byte. The engine frames the command byte or bytes for the selected address space. It clocks them out in SPI mode 0, followed by the data byte. It then returns the byte captured during the final slot, with a one-cycle completion pulse.

Requests use a valid/ready handshake. A request is taken on a rising clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the engine is idle, so the host applies back-pressure simply by holding `req_valid` and its fields until ready returns. Fields are captured at acceptance and may change freely afterwards. Chip select frames the whole transaction. Programmable idle gaps, counted in system clock cycles, are placed before the first byte, between bytes, before chip select is released and after it is released. The SCK half-period is also a parameter. The defaults, with a 250 MHz system clock, give gaps of 1 µs and a 500 kHz SCK.

Top module: `radio_spi_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `spi_mosi` is 0, `req_ready` is 1, `done` is 0 and `rd_data` is 0x00.
- R2: SCK idles low. Each bit holds SCK low for HALF_CYC cycles and then high for HALF_CYC cycles. MOSI changes only while SCK is low and is constant during each high phase. Bytes go out MSB first, and MISO is sampled on the clock edge that raises SCK.
- R3: A short-space access sends one command byte. Bit 7 is 0, bits 6..1 hold address bits [5:0], and bit 0 is 1 for a write and 0 for a read. Address bits [9:6] are ignored.
- R4: A long-space access sends two command bytes. The first has bit 7 set to 1, with address bits [9:3] in bits 6..0. The second has address bits [2:0] in bits 7..5, bit 4 set to 1 for a write and 0 for a read, and bits 3..0 set to 0.
- R5: After the command bytes, a write sends `req_wdata`. A read sends 0xFF, and the byte received on MISO during that slot appears on `rd_data` in the cycle `done` is high.
- R6: `spi_cs_n` falls on the acceptance edge. It stays low for GAP_CYC cycles before the first SCK low phase, for GAP_CYC cycles between the end of one byte and the low phase of the next, and for GAP_CYC cycles after the last SCK fall. `spi_cs_n` then stays high for GAP_CYC cycles before `done`.
- R7: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is low from the acceptance edge until the `done` cycle. Requests and field changes presented while busy have no effect on the transaction in progress.
- R8: `done` is a single-cycle pulse, and `req_ready` is high in that cycle. `rd_data` changes only on completion of a read and keeps its value across writes and idle time.
- R9: While `spi_cs_n` is high, `spi_sck` and `spi_mosi` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_long | input | 1 | 1 = 10-bit address space, 0 = 6-bit |
| req_addr | input | 10 | Register address (bits [9:6] unused for short space) |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured in the last slot of a read |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The assertions watch, on every cycle, the pin-level invariants. SCK and MOSI must be quiet whenever chip select is high. MOSI must not move during an SCK high phase. Chip select may fall only on an acceptance edge. `done` must be a lone pulse with chip select already released, and `rd_data` may change only with `done`. Ready must drop after acceptance. The exact byte contents of both framings, the MSB-first order, the gap lengths, the MISO capture slot, and the fact that fields changing during a busy transaction are ignored can be shown only by the bench. Its behavioural model predicts every sample of CS, SCK, MOSI, ready, done and read data for each scenario.

// File: rtl/rspi_pkg.sv
package rspi_pkg;
  localparam int LONG_AW  = 10;
  localparam int SHORT_AW = 6;
  localparam logic [7:0] DUMMY_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_BYTE,
    ST_TAIL,
    ST_POST
  } seq_state_t;

  // Bytes of one transaction in send order; last = index of the final byte.
  typedef struct packed {
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] b2;
    logic [1:0] last;
    logic       wr;
  } frame_t;
endpackage

// File: rtl/rspi_framer.sv
module rspi_framer
  import rspi_pkg::*;
(
  input  logic               is_write,
  input  logic               is_long,
  input  logic [LONG_AW-1:0] addr,
  input  logic [7:0]         wdata,
  output frame_t             frame
);
  logic [7:0] data_byte;

  always_comb begin
    data_byte = is_write ? wdata : DUMMY_BYTE;
    frame.wr  = is_write;
    if (is_long) begin
      frame.b0   = {1'b1, addr[LONG_AW-1:3]};
      frame.b1   = {addr[2:0], is_write, 4'b0000};
      frame.b2   = data_byte;
      frame.last = 2'd2;
    end else begin
      frame.b0   = {1'b0, addr[SHORT_AW-1:0], is_write};
      frame.b1   = data_byte;
      frame.b2   = 8'h00;
      frame.last = 2'd1;
    end
  end
endmodule

// File: rtl/rspi_shifter.sv
module rspi_shifter #(
  parameter int HALF_CYC = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       last_edge,
  output logic       busy
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    sh;
  logic          phase_end;

  assign phase_end = busy && (cnt == CNT_END);
  assign last_edge = phase_end && sck && (bit_idx == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      rx_byte <= 8'h00;
      cnt     <= '0;
      bit_idx <= 3'd0;
      sh      <= 8'h00;
    end else if (start) begin
      busy    <= 1'b1;
      sh      <= tx_byte;
      mosi    <= tx_byte[7];
      bit_idx <= 3'd7;
      cnt     <= '0;
    end else if (busy) begin
      if (phase_end) begin
        cnt <= '0;
        if (!sck) begin
          sck     <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_idx == 3'd0) begin
            busy <= 1'b0;
            mosi <= 1'b0;
          end else begin
            bit_idx <= bit_idx - 3'd1;
            mosi    <= sh[6];
            sh      <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/radio_spi_engine.sv
module radio_spi_engine
  import rspi_pkg::*;
#(
  parameter int HALF_CYC = 250,
  parameter int GAP_CYC  = 250
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic                   req_long,
  input  logic [LONG_AW-1:0]     req_addr,
  input  logic [7:0]             req_wdata,
  output logic                   done,
  output logic [7:0]             rd_data,
  output logic                   spi_sck,
  output logic                   spi_mosi,
  input  logic                   spi_miso,
  output logic                   spi_cs_n
);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GW-1:0] GAP_END = GW'(GAP_CYC - 1);

  seq_state_t state;
  frame_t     frame_d, frame_q;
  logic [1:0] idx;
  logic [GW-1:0] gcnt;
  logic       gap_end, start, last_edge, sh_busy;
  logic [7:0] cur_byte, rx_byte;

  rspi_framer u_framer (
    .is_write (req_write),
    .is_long  (req_long),
    .addr     (req_addr),
    .wdata    (req_wdata),
    .frame    (frame_d)
  );

  always_comb begin
    case (idx)
      2'd0:    cur_byte = frame_q.b0;
      2'd1:    cur_byte = frame_q.b1;
      default: cur_byte = frame_q.b2;
    endcase
  end

  assign req_ready = (state == ST_IDLE);
  assign gap_end   = (gcnt == GAP_END);
  assign start     = (state == ST_GAP) && gap_end;

  rspi_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tx_byte   (cur_byte),
    .miso      (spi_miso),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .rx_byte   (rx_byte),
    .last_edge (last_edge),
    .busy      (sh_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      frame_q  <= '0;
      idx      <= 2'd0;
      gcnt     <= '0;
      spi_cs_n <= 1'b1;
      done     <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          frame_q  <= frame_d;
          idx      <= 2'd0;
          gcnt     <= '0;
          spi_cs_n <= 1'b0;
          state    <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_end) begin
            gcnt  <= '0;
            state <= ST_BYTE;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        ST_BYTE: if (last_edge) begin
          if (idx == frame_q.last) begin
            state <= ST_TAIL;
          end else begin
            idx   <= idx + 2'd1;
            state <= ST_GAP;
          end
        end
        ST_TAIL: begin
          if (gap_end) begin
            gcnt     <= '0;
            spi_cs_n <= 1'b1;
            state    <= ST_POST;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        ST_POST: begin
          if (gap_end) begin
            gcnt  <= '0;
            done  <= 1'b1;
            state <= ST_IDLE;
            if (!frame_q.wr) rd_data <= rx_byte;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic unused_busy;
  assign unused_busy = sh_busy;
endmodule

// File: rtl/rspi_engine_chk.sv
module rspi_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic [7:0] rd_data,
  input logic       spi_sck,
  input logic       spi_mosi,
  input logic       spi_cs_n
);
  assert_quiet_when_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (!spi_sck && !spi_mosi));

  assert_mosi_steady_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));

  assert_cs_falls_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(req_valid && req_ready));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && req_ready));

  assert_rdata_moves_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);
endmodule

bind radio_spi_engine rspi_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .rd_data   (rd_data),
  .spi_sck   (spi_sck),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n)
);

// File: tb/radio_spi_engine_test.sv
`timescale 1ns/1ps
module radio_spi_engine_test;
  localparam int HALF = 2;
  localparam int GAP  = 3;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_long = 1'b0;
  logic [9:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic spi_miso = 1'b0;
  logic req_ready, done, spi_sck, spi_mosi, spi_cs_n;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  radio_spi_engine #(.HALF_CYC(HALF), .GAP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_long(req_long), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  typedef struct {
    bit cs_n; bit sck; bit mosi; bit ready; bit done; bit miso;
    bit upd; bit [7:0] rd; string tag;
  } ent_t;

  ent_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit [7:0] exp_rd = 8'h00;
  bit finished = 1'b0;

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(string what, string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic ent_t idle_ent(string tag);
    ent_t e;
    e.cs_n = 1; e.sck = 0; e.mosi = 0; e.ready = 1; e.done = 0;
    e.miso = 0; e.upd = 0; e.rd = 0; e.tag = tag;
    return e;
  endfunction

  task automatic push(int n, bit cs_n, bit sck, bit mosi, bit miso, string tag);
    for (int i = 0; i < n; i++) begin
      ent_t e;
      e.cs_n = cs_n; e.sck = sck; e.mosi = mosi; e.ready = 0; e.done = 0;
      e.miso = miso; e.upd = 0; e.rd = 0; e.tag = tag;
      q.push_back(e);
    end
  endtask

  // Behavioural model: every expected sample of the transaction, built from the requirements.
  task automatic build(bit wr, bit lng, int addr, int wd, int resp);
    int b[3]; int r[3]; string t[3]; int n;
    ent_t e;
    if (lng) begin
      b[0] = 128 + (addr / 8);
      b[1] = (addr % 8) * 32 + (wr ? 16 : 0);
      b[2] = wr ? wd : 255;
      t[0] = "R4"; t[1] = "R4"; t[2] = "R5"; n = 3;
    end else begin
      b[0] = (addr % 64) * 2 + (wr ? 1 : 0);
      b[1] = wr ? wd : 255;
      b[2] = 0;
      t[0] = "R3"; t[1] = "R5"; t[2] = "R5"; n = 2;
    end
    r[0] = 8'h5A; r[1] = 8'h96; r[2] = 8'h33;
    r[n-1] = resp;
    push(GAP, 0, 0, 0, 0, "R6");
    for (int i = 0; i < n; i++) begin
      for (int k = 7; k >= 0; k--) begin
        push(HALF, 0, 0, (b[i] >> k) & 1, (r[i] >> k) & 1, t[i]);
        push(HALF, 0, 1, (b[i] >> k) & 1, (r[i] >> k) & 1, "R2");
      end
      if (i != n - 1) push(GAP, 0, 0, 0, 0, "R6");
    end
    push(GAP, 0, 0, 0, 0, "R6");
    push(GAP, 1, 0, 0, 0, "R6");
    e = idle_ent("R8");
    e.done = 1; e.upd = !wr; e.rd = resp[7:0];
    q.push_back(e);
  endtask

  task automatic step();
    ent_t e;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      summary();
    end
    if (q.size() > 0) e = q.pop_front();
    else e = idle_ent("R9");
    if (e.upd) exp_rd = e.rd;
    chk("cs_n", e.tag, spi_cs_n, e.cs_n);
    chk("sck",  e.tag, spi_sck,  e.sck);
    chk("mosi", e.tag, spi_mosi, e.mosi);
    chk("ready", e.done ? "R8" : "R7", req_ready, e.ready);
    chk("done", "R8", done, e.done);
    chk("rd_data", e.upd ? "R5" : "R8", rd_data, exp_rd);
    spi_miso = e.miso;
  endtask

  // Issue one request; with disturb, valid stays high and fields churn while busy (R7).
  task automatic run(bit wr, bit lng, int addr, int wd, int resp, bit disturb);
    req_valid = 1; req_write = wr; req_long = lng;
    req_addr = addr[9:0]; req_wdata = wd[7:0];
    build(wr, lng, addr, wd, resp);
    step();
    if (!disturb) req_valid = 0;
    while (q.size() > 0) begin
      step();
      if (disturb) begin
        if (q.size() == 0) req_valid = 0;
        else begin
          req_write = $urandom; req_long = $urandom;
          req_addr = 10'($urandom); req_wdata = 8'($urandom);
        end
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    // R1: reset levels, during and after reset
    repeat (2) @(negedge clk);
    chk("cs_n", "R1", spi_cs_n, 1);
    chk("sck", "R1", spi_sck, 0);
    chk("ready", "R1", req_ready, 1);
    chk("rd_data", "R1", rd_data, 0);
    rst_n = 1;
    for (int i = 0; i < 3; i++) step();

    run(1, 0, 10'h02A, 8'hA5, 8'h00, 0);   // R3 short write
    for (int i = 0; i < 4; i++) step();
    run(0, 0, 10'h3C5, 0, 8'hC3, 0);       // R3 upper bits ignored, R5 read
    run(1, 1, 10'h2B7, 8'h3C, 8'h11, 0);   // R4 long write back-to-back, R8 rd_data kept
    run(0, 1, 10'h3FF, 0, 8'h81, 0);       // R4 long read, all-ones address
    run(0, 1, 10'h000, 0, 8'h7E, 0);       // R4 long read, zero address
    for (int i = 0; i < 5; i++) step();
    run(0, 1, 10'h155, 0, 8'hE4, 1);       // R7 busy-time changes ignored
    for (int i = 0; i < 2; i++) step();
    run(1, 0, 10'h03F, 8'h00, 8'hFF, 1);   // R7 short write under churn, R8 rd_data held
    run(0, 0, 10'h000, 0, 8'h01, 0);       // R5 capture LSB only
    for (int i = 0; i < 6; i++) step();    // R9 idle quiet
    summary();
  end
endmodule